// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block gathers per-mailbox interrupt events for a message controller with a parameterised number of mailboxes (32 by default). Each mailbox is configured as receive or transmit, and only events that match that direction can reach a flag. Events are single-cycle pulses from the message engine: a message was stored, a transmission was acknowledged, or a remote-request data frame finished. When a mailbox has automatic remote-frame handling turned on, only the remote-completion pulse counts as its event. The plain store and acknowledge pulses are then ignored for that mailbox.

Software sees a small register window. It holds a mask word that decides which mailboxes may raise flags, a receive flag word and a transmit flag word. There are also two status words: one for pending received messages and one for acknowledged transmissions. The flag and status words are cleared by writing ones. Two aggregate lines, one for receive and one for transmit, stay high while any flag in their word is set. Disabling a mailbox drops its pending status. Its transmit-acknowledge status is kept.

Top module: `mbirq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the mask, both flag words and both status words, and holds `rx_irq` and `tx_irq` low.
- R2: A write to address 0 replaces the mask word, and the word reads back at address 0. An event on a mailbox whose mask bit is 0 sets its status bit but leaves its flag bit unchanged.
- R3: An enabled mailbox has `mb_dir` bit 0 (receive) and its auto-remote bit clear. A pulse on its `evt_stored` bit sets its receive flag (address 1, if the mailbox is masked in) and its pending bit (address 3) at the same clock edge.
- R4: An enabled mailbox has `mb_dir` bit 1 (transmit) and its auto-remote bit clear. A pulse on its `evt_tx_done` bit sets its transmit flag (address 2, if the mailbox is masked in) and its acknowledge bit (address 4) at the same clock edge.
- R5: Events that do not match the configured direction are ignored. This covers `evt_tx_done` on a receive mailbox and `evt_stored` on a transmit mailbox.
- R6: With its `mb_auto_rmt` bit set, a mailbox ignores `evt_stored` and `evt_tx_done`. An `evt_rmt_done` pulse then sets the receive flag and pending bit for a receive mailbox, or the transmit flag and acknowledge bit for a transmit mailbox.
- R7: Events on a mailbox whose `mb_en` bit is 0 are ignored. Each clock edge with `mb_en` low clears that mailbox's pending bit. Its acknowledge bit keeps its value while the mailbox is disabled.
- R8: `rx_irq` is high exactly while any receive flag bit is set, and `tx_irq` while any transmit flag bit is set. Each line falls only once every set flag of its word has been cleared.
- R9: Writing 1 to a bit at addresses 1 to 4 clears that bit, and writing 0 leaves it unchanged. Addresses 5 to 7 read as zero and ignore writes.
- R10: An event and a write-1-to-clear may hit the same flag or status bit in the same cycle. In that case the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_dir | input | NUM_MB | Per-mailbox direction, 1 = transmit, 0 = receive |
| mb_en | input | NUM_MB | Per-mailbox enable |
| mb_auto_rmt | input | NUM_MB | Per-mailbox automatic remote-frame handling |
| evt_stored | input | NUM_MB | Pulse: message stored in mailbox |
| evt_tx_done | input | NUM_MB | Pulse: mailbox message sent without error |
| evt_rmt_done | input | NUM_MB | Pulse: remote-request data frame completed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | NUM_MB | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | NUM_MB | Register read data (combinational) |
| rx_irq | output | 1 | Aggregate receive interrupt |
| tx_irq | output | 1 | Aggregate transmit interrupt |

## Verification
Every event, write and enable change takes effect at the first rising edge after it is presented. The new flag, status and interrupt values are therefore due one cycle after the stimulus. Read data is combinational over the stored words and follows `rd_addr` within the same cycle. The bench drives stimulus at the falling edge and lets one rising edge pass. At the next falling edge it advances its reference model and compares both interrupt lines and all five readable words. It steps `rd_addr` with small delays inside that half cycle, well clear of any active edge.

// File: rtl/mbirq_pkg.sv
package mbirq_pkg;

    localparam int MB_COUNT_DEF = 32;
    localparam int ADDR_W       = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MASK = 3'd0,
        ADR_RXF  = 3'd1,
        ADR_TXF  = 3'd2,
        ADR_PEND = 3'd3,
        ADR_ACK  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic mask;
        logic rxf;
        logic txf;
        logic pend;
        logic ack;
    } reg_sel_t;

    function automatic reg_sel_t decode_sel(input logic en, input logic [ADDR_W-1:0] addr);
        reg_sel_t s;
        s      = '0;
        s.mask = en && (addr == ADR_MASK);
        s.rxf  = en && (addr == ADR_RXF);
        s.txf  = en && (addr == ADR_TXF);
        s.pend = en && (addr == ADR_PEND);
        s.ack  = en && (addr == ADR_ACK);
        return s;
    endfunction

endpackage

// File: rtl/mbirq_router.sv
module mbirq_router #(
    parameter int NUM_MB = 32
) (
    input  logic [NUM_MB-1:0] mb_dir,
    input  logic [NUM_MB-1:0] mb_en,
    input  logic [NUM_MB-1:0] mb_auto_rmt,
    input  logic [NUM_MB-1:0] evt_stored,
    input  logic [NUM_MB-1:0] evt_tx_done,
    input  logic [NUM_MB-1:0] evt_rmt_done,
    output logic [NUM_MB-1:0] rx_evt,
    output logic [NUM_MB-1:0] tx_evt
);
    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        logic plain_hit;
        logic eff_hit;
        always_comb begin
            plain_hit = mb_dir[i] ? evt_tx_done[i] : evt_stored[i];
            eff_hit   = mb_en[i] & (mb_auto_rmt[i] ? evt_rmt_done[i] : plain_hit);
            rx_evt[i] = eff_hit & ~mb_dir[i];
            tx_evt[i] = eff_hit &  mb_dir[i];
        end
    end
endmodule

// File: rtl/mbirq_w1c_bank.sv
module mbirq_w1c_bank #(
    parameter int NUM_MB = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_MB-1:0] set_i,
    input  logic [NUM_MB-1:0] clr_i,
    input  logic [NUM_MB-1:0] drop_i,
    output logic [NUM_MB-1:0] q_o
);
    logic [NUM_MB-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= (q_r & ~clr_i & ~drop_i) | set_i;
    end

    assign q_o = q_r;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i))); // R10

    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (clr_i == '0 && drop_i == '0) |=> ((q_o & $past(q_o)) == $past(q_o))); // R9
endmodule

// File: rtl/mbirq_regfile.sv
module mbirq_regfile
    import mbirq_pkg::*;
#(
    parameter int NUM_MB = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NUM_MB-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NUM_MB-1:0] rxf_q,
    input  logic [NUM_MB-1:0] txf_q,
    input  logic [NUM_MB-1:0] pend_q,
    input  logic [NUM_MB-1:0] ack_q,
    output logic [NUM_MB-1:0] mask_q,
    output logic [NUM_MB-1:0] clr_rxf,
    output logic [NUM_MB-1:0] clr_txf,
    output logic [NUM_MB-1:0] clr_pend,
    output logic [NUM_MB-1:0] clr_ack,
    output logic [NUM_MB-1:0] rd_data
);
    reg_sel_t          sel;
    logic [NUM_MB-1:0] mask_r;

    assign sel = decode_sel(wr_en, wr_addr);

    always_ff @(posedge clk) begin
        if (rst)           mask_r <= '0;
        else if (sel.mask) mask_r <= wr_data;
    end

    assign mask_q   = mask_r;
    assign clr_rxf  = sel.rxf  ? wr_data : '0;
    assign clr_txf  = sel.txf  ? wr_data : '0;
    assign clr_pend = sel.pend ? wr_data : '0;
    assign clr_ack  = sel.ack  ? wr_data : '0;

    always_comb begin
        unique case (rd_addr)
            ADR_MASK: rd_data = mask_r;
            ADR_RXF:  rd_data = rxf_q;
            ADR_TXF:  rd_data = txf_q;
            ADR_PEND: rd_data = pend_q;
            ADR_ACK:  rd_data = ack_q;
            default:  rd_data = '0;
        endcase
    end

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == ADR_MASK) |=> $stable(mask_q)); // R2
endmodule

// File: rtl/mbirq_ctrl.sv
module mbirq_ctrl
    import mbirq_pkg::*;
#(
    parameter int NUM_MB = MB_COUNT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_MB-1:0] mb_dir,
    input  logic [NUM_MB-1:0] mb_en,
    input  logic [NUM_MB-1:0] mb_auto_rmt,
    input  logic [NUM_MB-1:0] evt_stored,
    input  logic [NUM_MB-1:0] evt_tx_done,
    input  logic [NUM_MB-1:0] evt_rmt_done,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NUM_MB-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NUM_MB-1:0] rd_data,
    output logic              rx_irq,
    output logic              tx_irq
);
    localparam logic [NUM_MB-1:0] NO_DROP = '0;

    logic [NUM_MB-1:0] rx_evt, tx_evt;
    logic [NUM_MB-1:0] mask_q, rxf_q, txf_q, pend_q, ack_q;
    logic [NUM_MB-1:0] clr_rxf, clr_txf, clr_pend, clr_ack;
    logic [NUM_MB-1:0] not_en;

    assign not_en = ~mb_en;

    mbirq_router #(.NUM_MB(NUM_MB)) u_router (
        .mb_dir(mb_dir), .mb_en(mb_en), .mb_auto_rmt(mb_auto_rmt),
        .evt_stored(evt_stored), .evt_tx_done(evt_tx_done),
        .evt_rmt_done(evt_rmt_done), .rx_evt(rx_evt), .tx_evt(tx_evt)
    );

    mbirq_regfile #(.NUM_MB(NUM_MB)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rxf_q(rxf_q), .txf_q(txf_q),
        .pend_q(pend_q), .ack_q(ack_q), .mask_q(mask_q), .clr_rxf(clr_rxf),
        .clr_txf(clr_txf), .clr_pend(clr_pend), .clr_ack(clr_ack),
        .rd_data(rd_data)
    );

    mbirq_w1c_bank #(.NUM_MB(NUM_MB)) u_rxf (
        .clk(clk), .rst(rst), .set_i(rx_evt & mask_q), .clr_i(clr_rxf),
        .drop_i(NO_DROP), .q_o(rxf_q)
    );

    mbirq_w1c_bank #(.NUM_MB(NUM_MB)) u_txf (
        .clk(clk), .rst(rst), .set_i(tx_evt & mask_q), .clr_i(clr_txf),
        .drop_i(NO_DROP), .q_o(txf_q)
    );

    mbirq_w1c_bank #(.NUM_MB(NUM_MB)) u_pend (
        .clk(clk), .rst(rst), .set_i(rx_evt), .clr_i(clr_pend),
        .drop_i(not_en), .q_o(pend_q)
    );

    mbirq_w1c_bank #(.NUM_MB(NUM_MB)) u_ack (
        .clk(clk), .rst(rst), .set_i(tx_evt), .clr_i(clr_ack),
        .drop_i(NO_DROP), .q_o(ack_q)
    );

    assign rx_irq = |rxf_q;
    assign tx_irq = |txf_q;

    AST_MASKED_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (mask_q != '1) |=> (((rxf_q | txf_q) & ~$past(rxf_q | txf_q) & ~$past(mask_q)) == '0)); // R2

    AST_RX_ONLY_RX_DIR: assert property (@(posedge clk) disable iff (rst)
        (mb_dir != '0) |=> ((rxf_q & ~$past(rxf_q) & $past(mb_dir)) == '0)); // R5

    AST_TX_ONLY_TX_DIR: assert property (@(posedge clk) disable iff (rst)
        (mb_dir != '1) |=> ((txf_q & ~$past(txf_q) & ~$past(mb_dir)) == '0)); // R5

    AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == ADR_ACK) |=> ((ack_q & $past(ack_q)) == $past(ack_q))); // R7

    AST_DISABLED_NO_PEND: assert property (@(posedge clk) disable iff (rst)
        (mb_en != '1) |=> ((pend_q & ~$past(mb_en)) == '0)); // R7

    AST_RX_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_irq) |-> (rxf_q == '0)); // R8
endmodule

// File: tb/mbirq_ctrl_bench.sv
`timescale 1ns/1ps
module mbirq_ctrl_bench;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] mb_dir = '0, mb_en = '0, mb_auto_rmt = '0;
    logic [N-1:0] evt_stored = '0, evt_tx_done = '0, evt_rmt_done = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0, rd_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] rd_data;
    logic         rx_irq, tx_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [N-1:0] m_mask = '0, m_rx = '0, m_tx = '0, m_pend = '0, m_ack = '0;

    always #2.5 clk = ~clk;

    mbirq_ctrl #(.NUM_MB(N)) u_mbirq_ctrl (
        .clk(clk), .rst(rst), .mb_dir(mb_dir), .mb_en(mb_en),
        .mb_auto_rmt(mb_auto_rmt), .evt_stored(evt_stored),
        .evt_tx_done(evt_tx_done), .evt_rmt_done(evt_rmt_done),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] clr_for(input logic [2:0] a);
        return (wr_en && wr_addr == a) ? wr_data : '0;
    endfunction

    // Reference model: derives next words from the requirement text
    task automatic model_step();
        logic [N-1:0] eff, rxe, txe, nm, nr, nt, np, na;
        eff = (mb_auto_rmt & evt_rmt_done) |
              (~mb_auto_rmt & ((mb_dir & evt_tx_done) | (~mb_dir & evt_stored)));
        eff = eff & mb_en;
        rxe = eff & ~mb_dir;
        txe = eff & mb_dir;
        nm  = (wr_en && wr_addr == 3'd0) ? wr_data : m_mask;
        nr  = (m_rx & ~clr_for(3'd1)) | (rxe & m_mask);
        nt  = (m_tx & ~clr_for(3'd2)) | (txe & m_mask);
        np  = (m_pend & ~clr_for(3'd3) & mb_en) | rxe;
        na  = (m_ack & ~clr_for(3'd4)) | txe;
        m_mask = nm; m_rx = nr; m_tx = nt; m_pend = np; m_ack = na;
    endtask

    task automatic check_all(input string tag);
        check(tag, "rx_irq R8", {{(N-1){1'b0}}, rx_irq}, {{(N-1){1'b0}}, |m_rx});
        check(tag, "tx_irq R8", {{(N-1){1'b0}}, tx_irq}, {{(N-1){1'b0}}, |m_tx});
        rd_addr = 3'd0; #0.1 check(tag, "mask R2", rd_data, m_mask);
        rd_addr = 3'd1; #0.1 check(tag, "rxflag R3", rd_data, m_rx);
        rd_addr = 3'd2; #0.1 check(tag, "txflag R4", rd_data, m_tx);
        rd_addr = 3'd3; #0.1 check(tag, "pend R7", rd_data, m_pend);
        rd_addr = 3'd4; #0.1 check(tag, "ack R7", rd_data, m_ack);
        rd_addr = 3'd6; #0.1 check(tag, "unmapped R9", rd_data, '0);
    endtask

    // Inputs already set at a falling edge; run one clock and compare
    task automatic step(input string tag);
        model_step();
        @(negedge clk);
        evt_stored = '0; evt_tx_done = '0; evt_rmt_done = '0;
        wr_en = 1'b0; wr_data = '0;
        check_all(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst = 1'b0;

        mb_en = '1; mb_dir = 32'hFFFF_0000;
        wr(3'd0, 32'h00FF_00FF); step("R2 mask write");
        evt_stored = 32'h0000_0101; step("R3 rx store masked/unmasked");
        evt_tx_done = 32'h0001_0100; step("R4 tx ack and R5 wrong dir");
        evt_stored = 32'h0002_0000; evt_tx_done = 32'h0000_0002; step("R5 mismatched dir");
        mb_auto_rmt = 32'h0004_0004;
        evt_stored = 32'h0000_0004; evt_tx_done = 32'h0004_0000; step("R6 auto ignores plain");
        evt_rmt_done = 32'h0004_0004; step("R6 remote done sets");
        mb_auto_rmt = '0;
        wr(3'd1, 32'h0000_0000); step("R9 write zero keeps");
        wr(3'd1, 32'h0000_0001); evt_stored = 32'h0000_0001; step("R10 set beats clear");
        wr(3'd1, 32'h0000_0005); step("R8 rx irq falls");
        mb_en = 32'hFFFE_FFFE; evt_tx_done = 32'h0001_0000; evt_stored = 32'h0000_0001;
        step("R7 disabled ignored, pending dropped, ack kept");
        wr(3'd7, '1); step("R9 unmapped write ignored");
        wr(3'd2, '1); step("R8 tx irq falls");
        wr(3'd4, 32'h0001_0000); step("R9 ack cleared");
        wr(3'd3, '1); step("R9 pend cleared");

        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 16) == 0) mb_dir = $urandom;
            if (($urandom % 16) == 0) mb_en = $urandom | $urandom;
            if (($urandom % 16) == 0) mb_auto_rmt = $urandom & $urandom;
            evt_stored   = $urandom & $urandom & $urandom;
            evt_tx_done  = $urandom & $urandom & $urandom;
            evt_rmt_done = $urandom & $urandom & $urandom;
            if (($urandom % 3) == 0) wr(3'($urandom % 8), $urandom);
            step("R10 random");
        end

        rst = 1'b1;
        m_mask = '0; m_rx = '0; m_tx = '0; m_pend = '0; m_ack = '0;
        @(negedge clk);
        check_all("R1 reset again");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule